// File: doc/BRIEF.md
# Load/Store Address Decoder with Serial-Port Registers

This block sits between a CPU's load/store port and the things those accesses can reach: a word-organised data RAM, a dual-ported instruction RAM that shares the same write traffic, and a byte-wide serial port with ready/valid handshakes on both directions. On every cycle it classifies the CPU address. It steers stores to the RAM byte enables or to the serial transmit register. It also registers which source must answer a load, so that the returned word lines up with the one-cycle latency of a synchronous RAM.

Decoding is deliberately partial. A single address bit marks memory, and a single value of the top nibble marks I/O, where the low byte picks the function. The serial port's ready/valid pair is mapped onto three register offsets: a status word, a receive register and a transmit register. The block generates the one-cycle handshake pulses that a plain load or store cannot express by itself.

Top module: `mmio_uart_decode`

## Requirements
- R1: An access is a memory access whenever address bit 28 is 1, whatever the other upper address bits hold (e.g. 0x9xxxxxxx and 0xFxxxxxxx are memory). A memory load returns the RAM read word.
- R2: A memory store drives the same byte enables (equal to the CPU write strobes) on both the data RAM and the instruction RAM in the store cycle, with word address = address bits [13:2] and the CPU write data on both. No RAM enable is raised in any other case.
- R3: An access is an I/O access only when address bits [31:28] equal 4'h8. Address bits [7:0] choose the function, and bits [27:8] are ignored.
- R4: A load from I/O offset 0x00 returns a status word with bit 1 = receive-data-valid and bit 0 = transmit-ready, both sampled in the load cycle, and all other bits zero.
- R5: A load from I/O offset 0x04 returns the received byte in bits [7:0] with bits [31:8] zero. It also raises the receive-ready (consume) output for exactly the one cycle after the load.
- R6: A store to I/O offset 0x08 raises transmit-valid for exactly the one cycle after the store. The transmit byte output carries write-data bits [7:0] from that cycle onward and is held until the next such store.
- R7: Stores to any other I/O offset (including 0x00 and 0x04), and stores to addresses that are neither memory nor I/O, change no RAM enable and no handshake output. Loads from undefined I/O offsets (including write-only 0x08) or from unmapped addresses return zero and do not raise receive-ready.
- R8: Read data for a load appears on the CPU read port in the cycle after the load, because the source select is registered. Back-to-back loads from different sources each return their own value. In a cycle that follows no load, the read port is zero.
- R9: While reset is asserted, transmit-valid and receive-ready are low and the CPU read port is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_rd | input | 1 | Load request this cycle |
| cpu_wr | input | 1 | Store request this cycle |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data, already lane-aligned |
| cpu_wstrb | input | 4 | Store byte strobes |
| cpu_rdata | output | 32 | Load result, valid the cycle after the load |
| dram_we | output | 4 | Data RAM byte write enables |
| dram_addr | output | 12 | Data RAM word address |
| dram_wdata | output | 32 | Data RAM write data |
| dram_rdata | input | 32 | Data RAM synchronous read data |
| iram_we | output | 4 | Instruction RAM byte write enables |
| iram_addr | output | 12 | Instruction RAM word address (write port) |
| iram_wdata | output | 32 | Instruction RAM write data |
| uart_tx_data | output | 8 | Byte offered to the serial transmitter |
| uart_tx_valid | output | 1 | Transmit byte valid pulse |
| uart_tx_ready | input | 1 | Transmitter can accept a byte |
| uart_rx_data | input | 8 | Byte from the serial receiver |
| uart_rx_valid | input | 1 | Receiver holds an unread byte |
| uart_rx_ready | output | 1 | Consume pulse for the received byte |

## Verification
The bench targets the decode boundaries. Addresses such as 0xF0000008 and 0x90000004 carry bit 28 together with I/O-looking offsets. A decoder that compared the whole top nibble for memory, or let the low byte win, would skip the RAM write or emit a spurious transmit pulse. Stores to the status and receive offsets, and loads from the write-only transmit offset, must stay silent; a loose offset compare would pulse a handshake or return garbage. The bench also issues a RAM load followed at once by a receive load. A select that is not registered, or is registered one cycle too long, would return the wrong word in one of the two cycles. It further checks that both handshake pulses drop after one cycle while the transmit byte stays put.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_RAM  = 2'd1,
      SRC_IO   = 2'd2
   } rd_src_e;
endpackage

// File: rtl/mmio_addr_class.sv
module mmio_addr_class #(
   parameter int          AW      = 32,
   parameter int          MEM_BIT = 28,
   parameter logic [3:0]  IO_NIB  = 4'h8,
   parameter int          FN_W    = 8
) (
   input  logic [AW-1:0]   addr,
   output logic            is_mem,
   output logic            is_io,
   output logic [FN_W-1:0] fn
);
   localparam int NIB_LO = AW - 4;

   if (MEM_BIT >= AW) begin : g_bad_membit
      $error("MEM_BIT must lie inside the address");
   end
   if (FN_W > NIB_LO) begin : g_bad_fnw
      $error("function field overlaps the I/O nibble");
   end

   logic nib_hit;
   assign nib_hit = (addr[AW-1:NIB_LO] == IO_NIB);
   assign is_mem  = addr[MEM_BIT];
   // memory wins if a chosen I/O nibble also carries the memory bit
   assign is_io   = nib_hit && !addr[MEM_BIT];
   assign fn      = addr[FN_W-1:0];
endmodule

// File: rtl/mmio_uart_regs.sv
module mmio_uart_regs #(
   parameter int              DW       = 32,
   parameter int              FN_W     = 8,
   parameter int              BYTE_W   = 8,
   parameter logic [FN_W-1:0] OFF_STAT = 8'h00,
   parameter logic [FN_W-1:0] OFF_RX   = 8'h04,
   parameter logic [FN_W-1:0] OFF_TX   = 8'h08,
   parameter bit              HS_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld,
   input  logic              st,
   input  logic              is_io,
   input  logic [FN_W-1:0]   fn,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   output logic              rx_ready,
   output logic              io_hit,
   output logic [DW-1:0]     io_rdata
);
   if (DW < BYTE_W || DW < 2) begin : g_bad_dw
      $error("data word narrower than a serial byte");
   end

   logic ld_stat, ld_rx, st_tx;
   assign ld_stat = ld && is_io && (fn == OFF_STAT);
   assign ld_rx   = ld && is_io && (fn == OFF_RX);
   assign st_tx   = st && is_io && (fn == OFF_TX);
   assign io_hit  = ld_stat || ld_rx;

   logic [DW-1:0] stat_word, rx_word;
   always_comb begin
      stat_word              = '0;
      stat_word[1]           = rx_valid;
      stat_word[0]           = tx_ready;
      rx_word                = '0;
      rx_word[BYTE_W-1:0]    = rx_data;
   end

   always_ff @(posedge clk) begin
      if (rst)          io_rdata <= '0;
      else if (ld_stat) io_rdata <= stat_word;
      else if (ld_rx)   io_rdata <= rx_word;
      else              io_rdata <= '0;
   end

   if (HS_REG) begin : g_hs_reg
      logic              txv_q, rxr_q;
      logic [BYTE_W-1:0] txd_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            txv_q <= 1'b0;
            rxr_q <= 1'b0;
            txd_q <= '0;
         end else begin
            txv_q <= st_tx;
            rxr_q <= ld_rx;
            if (st_tx) txd_q <= wbyte;
         end
      end
      assign tx_valid = txv_q;
      assign rx_ready = rxr_q;
      assign tx_data  = txd_q;

      // R6: a transmit pulse always follows a store
      a_r6_txv_after_store: assert property (@(posedge clk) disable iff (rst)
         tx_valid |-> $past(st));
      // R6: transmit byte moves only after a store
      a_r6_txd_held: assert property (@(posedge clk) disable iff (rst)
         !$past(st) |-> $stable(tx_data));
      // R5: a consume pulse always follows a load
      a_r5_rxr_after_load: assert property (@(posedge clk) disable iff (rst)
         rx_ready |-> $past(ld));
   end else begin : g_hs_comb
      assign tx_valid = st_tx;
      assign rx_ready = ld_rx;
      assign tx_data  = wbyte;
   end
endmodule

// File: rtl/mmio_rd_mux.sv
module mmio_rd_mux
   import mmio_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ld,
   input  logic          is_mem,
   input  logic          io_hit,
   input  logic [DW-1:0] ram_rdata,
   input  logic [DW-1:0] io_rdata,
   output logic [DW-1:0] rdata
);
   rd_src_e sel_q;

   always_ff @(posedge clk) begin
      if (rst)                 sel_q <= SRC_NONE;
      else if (ld && is_mem)   sel_q <= SRC_RAM;
      else if (ld && io_hit)   sel_q <= SRC_IO;
      else                     sel_q <= SRC_NONE;
   end

   always_comb begin
      case (sel_q)
         SRC_RAM: rdata = ram_rdata;
         SRC_IO:  rdata = io_rdata;
         default: rdata = '0;
      endcase
   end

   // R8: RAM is selected only in the cycle after a memory load
   a_r8_ram_after_load: assert property (@(posedge clk) disable iff (rst)
      (sel_q == SRC_RAM) |-> $past(ld && is_mem));
endmodule

// File: rtl/mmio_uart_decode.sv
module mmio_uart_decode #(
   parameter int          AW      = 32,
   parameter int          DW      = 32,
   parameter int          RAW     = 12,
   parameter int          MEM_BIT = 28,
   parameter logic [3:0]  IO_NIB  = 4'h8,
   parameter int          FN_W    = 8,
   parameter bit          HS_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cpu_rd,
   input  logic             cpu_wr,
   input  logic [31:0]      cpu_addr,
   input  logic [31:0]      cpu_wdata,
   input  logic [3:0]       cpu_wstrb,
   output logic [31:0]      cpu_rdata,
   output logic [3:0]       dram_we,
   output logic [11:0]      dram_addr,
   output logic [31:0]      dram_wdata,
   input  logic [31:0]      dram_rdata,
   output logic [3:0]       iram_we,
   output logic [11:0]      iram_addr,
   output logic [31:0]      iram_wdata,
   output logic [7:0]       uart_tx_data,
   output logic             uart_tx_valid,
   input  logic             uart_tx_ready,
   input  logic [7:0]       uart_rx_data,
   input  logic             uart_rx_valid,
   output logic             uart_rx_ready
);
   localparam int NB        = DW / 8;
   localparam int LANE_BITS = $clog2(NB);
   localparam int BYTE_W    = 8;

   if (AW != 32 || DW != 32 || RAW != 12) begin : g_bad_port_widths
      $error("port widths are fixed at 32/32/12");
   end
   if (RAW + LANE_BITS > MEM_BIT) begin : g_bad_raw
      $error("RAM index reaches the memory select bit");
   end

   logic            is_mem, is_io;
   logic [FN_W-1:0] fn;
   logic            io_hit;
   logic [DW-1:0]   io_rdata;
   logic            mem_st;

   mmio_addr_class #(
      .AW(AW), .MEM_BIT(MEM_BIT), .IO_NIB(IO_NIB), .FN_W(FN_W)
   ) u_class (
      .addr(cpu_addr), .is_mem(is_mem), .is_io(is_io), .fn(fn)
   );

   assign mem_st = cpu_wr && is_mem;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign dram_we[b] = mem_st && cpu_wstrb[b];
      assign iram_we[b] = mem_st && cpu_wstrb[b];
   end

   assign dram_addr  = cpu_addr[RAW+LANE_BITS-1:LANE_BITS];
   assign iram_addr  = cpu_addr[RAW+LANE_BITS-1:LANE_BITS];
   assign dram_wdata = cpu_wdata;
   assign iram_wdata = cpu_wdata;

   mmio_uart_regs #(
      .DW(DW), .FN_W(FN_W), .BYTE_W(BYTE_W), .HS_REG(HS_REG)
   ) u_uart (
      .clk(clk), .rst(rst), .ld(cpu_rd), .st(cpu_wr), .is_io(is_io),
      .fn(fn), .wbyte(cpu_wdata[BYTE_W-1:0]),
      .rx_valid(uart_rx_valid), .rx_data(uart_rx_data),
      .tx_ready(uart_tx_ready), .tx_valid(uart_tx_valid),
      .tx_data(uart_tx_data), .rx_ready(uart_rx_ready),
      .io_hit(io_hit), .io_rdata(io_rdata)
   );

   mmio_rd_mux #(.DW(DW)) u_mux (
      .clk(clk), .rst(rst), .ld(cpu_rd), .is_mem(is_mem), .io_hit(io_hit),
      .ram_rdata(dram_rdata), .io_rdata(io_rdata), .rdata(cpu_rdata)
   );

   // R2: RAM enables only on a store with the memory bit set
   a_r2_we_needs_mem_store: assert property (@(posedge clk) disable iff (rst)
      (|dram_we || |iram_we) |-> (cpu_wr && cpu_addr[MEM_BIT]));
   // R7: nothing reaches the RAMs on a pure load
   a_r7_load_no_we: assert property (@(posedge clk) disable iff (rst)
      (cpu_rd && !cpu_wr) |-> (dram_we == '0 && iram_we == '0));
   // R7: I/O-nibble addresses never write memory
   a_r7_io_no_we: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr[31:28] == IO_NIB && !cpu_addr[MEM_BIT]) |-> (dram_we == '0));
   // R9: handshakes quiet right after a reset cycle
   a_r9_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (!uart_tx_valid && !uart_rx_ready));
endmodule

// File: tb/sim_mmio_uart_decode.sv
module sim_mmio_uart_decode;
   localparam logic [31:0] RAMVAL = 32'hCAFE_F00D;

   typedef struct packed {
      logic [3:0]  req;
      logic        rd;
      logic        wr;
      logic [31:0] addr;
      logic [3:0]  strb;
      logic [31:0] wdata;
      logic        rxv;
      logic [7:0]  rxd;
      logic        txr;
      logic [3:0]  exp_we;
      logic [31:0] exp_rd;
      logic        exp_txv;
      logic        exp_rxr;
      logic [7:0]  exp_txd;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      // R1 plain memory load
      '{4'd1, 1'b1, 1'b0, 32'h1000_0010, 4'h0, 32'h0, 1'b0, 8'h00, 1'b0, 4'h0, RAMVAL, 1'b0, 1'b0, 8'h00},
      // R2 full-word store to both RAMs
      '{4'd2, 1'b0, 1'b1, 32'h1000_0024, 4'hF, 32'hDEAD_BEEF, 1'b0, 8'h00, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0, 8'h00},
      // R1 top nibble F with bit 28 set and offset 0x08 is memory
      '{4'd1, 1'b0, 1'b1, 32'hF000_0008, 4'h4, 32'h00AB_0000, 1'b0, 8'h00, 1'b1, 4'h4, 32'h0, 1'b0, 1'b0, 8'h00},
      // R4 status: rx valid, tx busy
      '{4'd4, 1'b1, 1'b0, 32'h8000_0000, 4'h0, 32'h0, 1'b1, 8'h00, 1'b0, 4'h0, 32'h2, 1'b0, 1'b0, 8'h00},
      // R3 middle bits ignored, status: tx ready only
      '{4'd3, 1'b1, 1'b0, 32'h8123_4500, 4'h0, 32'h0, 1'b0, 8'h00, 1'b1, 4'h0, 32'h1, 1'b0, 1'b0, 8'h00},
      // R5 receive byte and consume pulse
      '{4'd5, 1'b1, 1'b0, 32'h8000_0004, 4'h0, 32'h0, 1'b1, 8'h5A, 1'b0, 4'h0, 32'h5A, 1'b0, 1'b1, 8'h00},
      // R6 transmit low byte
      '{4'd6, 1'b0, 1'b1, 32'h8000_0008, 4'hF, 32'h1234_56C3, 1'b0, 8'h00, 1'b1, 4'h0, 32'h0, 1'b1, 1'b0, 8'hC3},
      // R7 store to undefined offset
      '{4'd7, 1'b0, 1'b1, 32'h8000_000C, 4'hF, 32'h0000_0077, 1'b0, 8'h00, 1'b1, 4'h0, 32'h0, 1'b0, 1'b0, 8'h00},
      // R7 load from undefined offset
      '{4'd7, 1'b1, 1'b0, 32'h8000_0010, 4'h0, 32'h0, 1'b1, 8'h11, 1'b1, 4'h0, 32'h0, 1'b0, 1'b0, 8'h00},
      // R7 unmapped load
      '{4'd7, 1'b1, 1'b0, 32'h0000_0004, 4'h0, 32'h0, 1'b1, 8'h22, 1'b1, 4'h0, 32'h0, 1'b0, 1'b0, 8'h00},
      // R1 nibble 9 is memory, not the receive register
      '{4'd1, 1'b1, 1'b0, 32'h9000_0004, 4'h0, 32'h0, 1'b1, 8'h33, 1'b1, 4'h0, RAMVAL, 1'b0, 1'b0, 8'h00},
      // R7 store to status offset ignored
      '{4'd7, 1'b0, 1'b1, 32'h8000_0000, 4'hF, 32'h0000_0099, 1'b0, 8'h00, 1'b1, 4'h0, 32'h0, 1'b0, 1'b0, 8'h00},
      // R7 load from write-only transmit offset
      '{4'd7, 1'b1, 1'b0, 32'h8000_0008, 4'h0, 32'h0, 1'b1, 8'h44, 1'b1, 4'h0, 32'h0, 1'b0, 1'b0, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]  cpu_wstrb = '0;
   logic [31:0] cpu_rdata;
   logic [3:0]  dram_we, iram_we;
   logic [11:0] dram_addr, iram_addr;
   logic [31:0] dram_wdata, iram_wdata;
   logic [31:0] dram_rdata = RAMVAL;
   logic [7:0]  uart_tx_data;
   logic        uart_tx_valid;
   logic        uart_tx_ready = 1'b0;
   logic [7:0]  uart_rx_data = '0;
   logic        uart_rx_valid = 1'b0;
   logic        uart_rx_ready;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   mmio_uart_decode u0 (
      .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb),
      .cpu_rdata(cpu_rdata), .dram_we(dram_we), .dram_addr(dram_addr),
      .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .iram_we(iram_we),
      .iram_addr(iram_addr), .iram_wdata(iram_wdata),
      .uart_tx_data(uart_tx_data), .uart_tx_valid(uart_tx_valid),
      .uart_tx_ready(uart_tx_ready), .uart_rx_data(uart_rx_data),
      .uart_rx_valid(uart_rx_valid), .uart_rx_ready(uart_rx_ready)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_bus();
      cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wstrb = '0;
   endtask

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      chk("R9 tx_valid in reset", {31'b0, uart_tx_valid}, 32'h0);
      chk("R9 rx_ready in reset", {31'b0, uart_rx_ready}, 32'h0);
      chk("R9 rdata in reset", cpu_rdata, 32'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string tag;
         v = VECS[i];
         tag = $sformatf("R%0d vec%0d", v.req, i);
         @(negedge clk);
         cpu_rd = v.rd; cpu_wr = v.wr; cpu_addr = v.addr;
         cpu_wstrb = v.strb; cpu_wdata = v.wdata;
         uart_rx_valid = v.rxv; uart_rx_data = v.rxd; uart_tx_ready = v.txr;
         #1;
         chk({tag, " dram_we"}, {28'b0, dram_we}, {28'b0, v.exp_we});
         chk({tag, " iram_we"}, {28'b0, iram_we}, {28'b0, v.exp_we});
         if (v.exp_we != 4'h0) begin
            chk({tag, " dram_addr"}, {20'b0, dram_addr}, {20'b0, v.addr[13:2]});
            chk({tag, " iram_addr"}, {20'b0, iram_addr}, {20'b0, v.addr[13:2]});
            chk({tag, " iram_wdata"}, iram_wdata, v.wdata);
         end
         @(posedge clk); #1;
         idle_bus();
         chk({tag, " rdata"}, cpu_rdata, v.exp_rd);
         chk({tag, " tx_valid"}, {31'b0, uart_tx_valid}, {31'b0, v.exp_txv});
         chk({tag, " rx_ready"}, {31'b0, uart_rx_ready}, {31'b0, v.exp_rxr});
         if (v.exp_txv) chk({tag, " tx_data"}, {24'b0, uart_tx_data}, {24'b0, v.exp_txd});
      end

      // R6 pulse lasts one cycle, byte held afterwards
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = 32'h8000_0008; cpu_wdata = 32'h0000_00A5; cpu_wstrb = 4'hF;
      @(posedge clk); #1;
      idle_bus();
      chk("R6 pulse high", {31'b0, uart_tx_valid}, 32'h1);
      @(posedge clk); #1;
      chk("R6 pulse low next cycle", {31'b0, uart_tx_valid}, 32'h0);
      chk("R6 byte held", {24'b0, uart_tx_data}, 32'hA5);

      // R8 back-to-back loads from RAM then receive register
      @(negedge clk);
      cpu_rd = 1'b1; cpu_addr = 32'h1000_0000;
      @(posedge clk); #1;
      cpu_addr = 32'h8000_0004; uart_rx_data = 8'h77; uart_rx_valid = 1'b1;
      chk("R8 first load RAM", cpu_rdata, RAMVAL);
      chk("R8 no consume on RAM load", {31'b0, uart_rx_ready}, 32'h0);
      @(posedge clk); #1;
      idle_bus();
      chk("R8 second load receive", cpu_rdata, 32'h77);
      chk("R5 consume pulse", {31'b0, uart_rx_ready}, 32'h1);
      @(posedge clk); #1;
      chk("R8 zero after no load", cpu_rdata, 32'h0);
      chk("R5 consume one cycle", {31'b0, uart_rx_ready}, 32'h0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule